// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is a byte-wide synchronous serial shifter for a small controller. It has one data register that software reads and writes over a byte-wide register bus, and a control register that selects the mode and the shift rate. Writing the busy bit starts a transfer. As master, the block makes its own shift clock from the system clock. As slave, it follows a shift clock that arrives on a pin. Data leaves on the serial output and enters on the serial input, most significant bit first.

Each rising edge of the effective shift clock moves the serial input into the low end of the register. The serial output changes only on falling edges. In master mode, hardware clears busy after the eighth clock period. Software can clear busy earlier, and the transfer then stops with fewer bits shifted. In slave mode, busy clears on the eighth rising edge. After that the register keeps shifting for as long as the remote clock runs, until software disables the port or selects master mode. The external clock and the serial input pass through synchronizer flops before edge detection. Pin drivers are represented only by output-enable signals.

A state machine with five states controls the port. `ST_IDLE` means nothing is shifting. `ST_M_LOW` and `ST_M_HIGH` are the two halves of a generated clock period. `ST_S_ARMED` is a counted slave transfer. `ST_S_FREE` is uncounted slave shifting after busy has cleared. The transitions are:
- start: `ST_IDLE` or `ST_S_FREE` goes to `ST_M_LOW` or `ST_S_ARMED`.
- rise: `ST_M_LOW` to `ST_M_HIGH` when a half-period ends.
- fall: `ST_M_HIGH` to `ST_M_LOW`, or to `ST_IDLE` after the eighth bit.
- count-done: `ST_S_ARMED` to `ST_S_FREE` on the eighth slave rising edge.
- abort: any busy state to `ST_IDLE` when busy or enable is written 0.
- release: `ST_S_FREE` to `ST_IDLE` when enable is cleared or master is selected.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, the data register reads 0x00, the control register reads 0x00, and `sclk_out`, `sclk_oe` and `sdo_oe` are all 0.
- R2: Control register (address 1) layout: bit 0 enable, bit 1 master, bits 3:2 rate, bit 7 busy. In master mode the shift clock period is 2 system clocks for rate 00, 4 for rate 01, and 8 for rate 10 or 11.
- R3: A master transfer produces exactly eight rising edges on `sclk_out` and then clears busy. At each rising edge `sdo` carries the loaded byte MSB first, and the data register (address 0) finally holds the eight `sdi` bits, first bit in the MSB.
- R4: Writing the control register with busy 0 during a transfer stops it at once. `sclk_out` stays low, busy reads 0, and the data register keeps the bits shifted so far.
- R5: In slave mode each rising edge on `sclk_in` shifts `sdi` into the register, `sdo` presents the loaded byte MSB first, and busy clears after eight rising edges.
- R6: In slave mode, once busy has cleared by count, further `sclk_in` rising edges keep shifting `sdi` into the register while busy stays 0.
- R7: Starting a slave transfer while `sclk_in` is already high shifts one bit immediately. That bit counts toward the eight, so seven further rising edges clear busy.
- R8: With enable 0, a write of busy 1 is ignored, edges on `sclk_in` do not change the data register, and writing enable 0 during a transfer ends it with `sclk_out` low.
- R9: A write to the data register while busy is 1 is ignored.
- R10: `sdo_oe` equals the enable bit, and `sclk_oe` is high only when both enable and master are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one cycle is the base unit of the master rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 data, 1 control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| sclk_in | input | 1 | Shift clock from the pin, used in slave mode |
| sclk_out | output | 1 | Generated shift clock, idles low |
| sclk_oe | output | 1 | Drive enable for the shift-clock pin |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the serial-output pin |

## Verification
The bench builds the block with its defaults: an 8-bit register, two synchronizer stages and a 3-bit half-period divider. These values make every rate code reachable, including the alias 11. They also make rates 10 and 11 long enough for the bench to change `sdi` after each observed falling edge and still get a clean capture through the synchronizer. The two-stage synchronizer sets the slave pulse spacing the bench uses. It also makes the immediate extra bit of R7 visible within a few cycles of the start write.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M_LOW,
        ST_M_HIGH,
        ST_S_ARMED,
        ST_S_FREE
    } ssp_state_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_MST_BIT  = 1;
    localparam int CTRL_RATE_LO  = 2;
    localparam int CTRL_BUSY_BIT = 7;

    typedef struct packed {
        logic       en;
        logic       master;
        logic [1:0] rate;
    } ssp_cfg_t;
endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ssp_mclk.sv
module ssp_mclk #(
    parameter int DIV_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_m1;

    // half period in system clocks: 1, 2, 4, 4
    always_comb begin
        unique case (rate)
            2'b00:   half_m1 = DIV_W'(0);
            2'b01:   half_m1 = DIV_W'(1);
            default: half_m1 = DIV_W'(3);
        endcase
    end

    assign tick = run && (cnt_q == half_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/ssp_core.sv
module ssp_core
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_ctrl_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              mtick,
    output ssp_cfg_t          cfg,
    output logic              busy,
    output logic              sck,
    output logic              mrun,
    output logic              sdo,
    output logic [DATA_W-1:0] shreg
);
    localparam int MSB = DATA_W - 1;

    ssp_state_e        state_q, state_d;
    ssp_cfg_t          cfg_q;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              sdo_q;
    logic              gclk_q;

    logic w_en, w_mst, w_busy;
    logic start, abort, release_free;
    logic slave_act, gclk, srise, sfall, mrise, mfall, shift_now;

    assign w_en   = wdata[CTRL_EN_BIT];
    assign w_mst  = wdata[CTRL_MST_BIT];
    assign w_busy = wdata[CTRL_BUSY_BIT];

    assign start        = wr_ctrl_en && w_busy && w_en;
    assign abort        = wr_ctrl_en && (!w_busy || !w_en);
    assign release_free = wr_ctrl_en && (!w_en || w_mst);

    assign slave_act = (state_q == ST_S_ARMED) || (state_q == ST_S_FREE);
    assign gclk      = sclk_s && slave_act;
    assign srise     = gclk && !gclk_q;
    assign sfall     = !gclk && gclk_q && slave_act;
    assign mrise     = (state_q == ST_M_LOW)  && mtick;
    assign mfall     = (state_q == ST_M_HIGH) && mtick;
    assign shift_now = mrise || srise;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = w_mst ? ST_M_LOW : ST_S_ARMED;
            end
            ST_M_LOW: begin
                if (abort)      state_d = ST_IDLE;
                else if (mtick) state_d = ST_M_HIGH;
            end
            ST_M_HIGH: begin
                if (abort)      state_d = ST_IDLE;
                else if (mtick) state_d = (cnt_q == CNT_W'(DATA_W)) ? ST_IDLE : ST_M_LOW;
            end
            ST_S_ARMED: begin
                if (abort) state_d = ST_IDLE;
                else if (srise && (cnt_q == CNT_W'(DATA_W - 1))) state_d = ST_S_FREE;
            end
            ST_S_FREE: begin
                if (start)             state_d = w_mst ? ST_M_LOW : ST_S_ARMED;
                else if (release_free) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        busy = 1'b0;
        sck  = 1'b0;
        mrun = 1'b0;
        unique case (state_q)
            ST_M_LOW:   begin busy = 1'b1; mrun = 1'b1; end
            ST_M_HIGH:  begin busy = 1'b1; mrun = 1'b1; sck = 1'b1; end
            ST_S_ARMED: busy = 1'b1;
            default:    ;
        endcase
    end

    // configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_ctrl_en) begin
            cfg_q.en     <= w_en;
            cfg_q.master <= w_mst;
            cfg_q.rate   <= wdata[CTRL_RATE_LO +: 2];
        end
    end

    // datapath: shift register, serial output, bit count, slave clock history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            sdo_q   <= 1'b0;
            cnt_q   <= '0;
            gclk_q  <= 1'b0;
        end else begin
            gclk_q <= gclk;

            if (wr_data_en && !busy) begin
                shreg_q <= wdata;
            end else if (shift_now) begin
                shreg_q <= {shreg_q[MSB-1:0], sdi_s};
            end

            if (wr_data_en && !busy) begin
                sdo_q <= wdata[MSB];
            end else if (start && !busy) begin
                sdo_q <= shreg_q[MSB];
            end else if (mfall || sfall) begin
                sdo_q <= shreg_q[MSB];
            end

            if (start && !busy) begin
                cnt_q <= '0;
            end else if (mrise || (srise && state_q == ST_S_ARMED)) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign cfg   = cfg_q;
    assign sdo   = sdo_q;
    assign shreg = shreg_q;

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DATA_W));

    a_r3_sdo_only_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (mrun && !mtick) |=> $stable(sdo_q));

    a_r9_reg_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !shift_now) |=> $stable(shreg_q));

    a_r4_abort_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl_en && !w_busy) |=> !busy);

    a_r8_no_busy_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> !busy);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_W       = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_in,
    output logic              sclk_out,
    output logic              sclk_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [1:0]        pin_sync;
    logic              mtick, busy, sck, mrun, sdo_core;
    ssp_cfg_t          cfg;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] ctrl_rd;

    ssp_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_in, sdi}),
        .q     (pin_sync)
    );

    ssp_mclk #(.DIV_W(DIV_W)) u_mclk (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mrun),
        .rate  (cfg.rate),
        .tick  (mtick)
    );

    ssp_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_data_en (bus_wr && !bus_addr),
        .wr_ctrl_en (bus_wr && bus_addr),
        .wdata      (bus_wdata),
        .sclk_s     (pin_sync[1]),
        .sdi_s      (pin_sync[0]),
        .mtick      (mtick),
        .cfg        (cfg),
        .busy       (busy),
        .sck        (sck),
        .mrun       (mrun),
        .sdo        (sdo_core),
        .shreg      (shreg)
    );

    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[CTRL_EN_BIT]        = cfg.en;
        ctrl_rd[CTRL_MST_BIT]       = cfg.master;
        ctrl_rd[CTRL_RATE_LO +: 2]  = cfg.rate;
        ctrl_rd[CTRL_BUSY_BIT]      = busy;
    end

    assign bus_rdata = bus_addr ? ctrl_rd : shreg;
    assign sclk_out  = sck;
    assign sclk_oe   = cfg.en && cfg.master;
    assign sdo       = sdo_core;
    assign sdo_oe    = cfg.en;

    a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> (!sclk_out && !busy));

    a_r10_clock_drive_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_oe |-> sdo_oe);
endmodule

// File: tb/sync_shift_port_tb.sv
`timescale 1ns/1ps
module sync_shift_port_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       addr = 0;
    logic       wr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       sclk_in = 0;
    logic       sclk_out, sclk_oe, sdi = 0, sdo, sdo_oe;
    int         checks = 0;
    int         failures = 0;
    bit         finished = 0;

    always #2 clk = ~clk;

    sync_shift_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr),
        .bus_wdata(wdata), .bus_rdata(rdata), .sclk_in(sclk_in),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #0.1;
        d = rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic s_pulse(input logic b, output logic sdo_seen);
        sdi = b;
        wait_cyc(4);
        sdo_seen = sdo;
        sclk_in = 1;
        wait_cyc(4);
        sclk_in = 0;
        wait_cyc(4);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(0, d); check(d == 8'h00, "R1 data after reset", d, 0);
        bus_read(1, d); check(d == 8'h00, "R1 ctrl after reset", d, 0);
        check({sclk_out, sclk_oe, sdo_oe} == 3'b000, "R1 pins after reset", {sclk_out, sclk_oe, sdo_oe}, 0);
    endtask

    task automatic t_master(input logic [1:0] rate, input logic [7:0] tx, input logic [7:0] rx, input bit vary);
        int rises = 0, last = -1, gap_bad = 0, cyc = 0, period;
        logic [7:0] cap = 0;
        logic [7:0] d;
        logic prev = 0;
        period = (rate == 2'b00) ? 2 : (rate == 2'b01) ? 4 : 8;
        bus_write(1, 8'h03);
        bus_write(0, tx);
        sdi = rx[7];
        bus_write(1, 8'h83 | {4'b0, rate, 2'b00});
        check(sclk_oe && sdo_oe, "R10 master enables", {sclk_oe, sdo_oe}, 3);
        addr = 1;
        while (cyc < 400) begin
            @(negedge clk); #0.1;
            cyc++;
            if (sclk_out && !prev) begin
                if (rises < 8) cap[7 - rises] = sdo;
                if (last >= 0 && (cyc - last) != period) gap_bad++;
                last = cyc;
                rises++;
            end
            if (!sclk_out && prev && vary && rises < 8) sdi = rx[7 - rises];
            prev = sclk_out;
            if (!rdata[7]) break;
        end
        check(rises == 8, "R3 rising edge count", rises, 8);
        check(cap == tx, "R3 sdo MSB first", cap, tx);
        check(gap_bad == 0, "R2 shift clock period", gap_bad, 0);
        bus_read(0, d);
        check(d == rx, "R3 received byte", d, rx);
    endtask

    task automatic t_abort_and_locked_data();
        int rises = 0, cyc = 0, late = 0;
        logic prev = 0;
        logic [7:0] d;
        bus_write(0, 8'h81);
        sdi = 0;
        bus_write(1, 8'h8F);
        while (cyc < 100 && rises < 2) begin
            @(negedge clk); cyc++;
            if (sclk_out && !prev) begin
                rises++;
                if (rises == 1) bus_write(0, 8'hFF);
                else bus_write(1, 8'h0F);
            end
            prev = sclk_out;
        end
        bus_read(1, d);
        check(d[7] == 1'b0, "R4 busy after abort", d[7], 0);
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (sclk_out) late++;
        end
        check(late == 0, "R4 clock quiet after abort", late, 0);
        bus_read(0, d);
        check(d == 8'h04, "R9 data write ignored while busy / R4 partial", d, 8'h04);
    endtask

    task automatic t_slave();
        logic [7:0] tx = 8'hC3, rx = 8'h5A, cap, d;
        logic s;
        bus_write(1, 8'h01);
        bus_write(0, tx);
        bus_write(1, 8'h81);
        check(sdo_oe && !sclk_oe, "R10 slave enables", {sclk_oe, sdo_oe}, 1);
        for (int i = 7; i >= 0; i--) begin
            s_pulse(rx[i], s);
            cap[i] = s;
        end
        check(cap == tx, "R5 slave sdo MSB first", cap, tx);
        bus_read(1, d);
        check(d[7] == 1'b0, "R5 busy clear after eight", d[7], 0);
        bus_read(0, d);
        check(d == rx, "R5 slave received byte", d, rx);
        s_pulse(1'b1, s);
        s_pulse(1'b1, s);
        bus_read(0, d);
        check(d == 8'h6B, "R6 shifting continues after busy", d, 8'h6B);
        bus_read(1, d);
        check(d[7] == 1'b0, "R6 busy stays clear", d[7], 0);
    endtask

    task automatic t_extra_bit();
        logic [7:0] d;
        logic s;
        bus_write(1, 8'h00);
        bus_write(0, 8'h00);
        sdi = 1; sclk_in = 1;
        wait_cyc(4);
        bus_write(1, 8'h81);
        wait_cyc(4);
        bus_read(0, d);
        check(d == 8'h01, "R7 immediate bit on start", d, 8'h01);
        sclk_in = 0;
        wait_cyc(4);
        for (int i = 0; i < 6; i++) s_pulse(1'b0, s);
        bus_read(1, d);
        check(d[7] == 1'b1, "R7 busy after seven edges", d[7], 1);
        s_pulse(1'b0, s);
        bus_read(1, d);
        check(d[7] == 1'b0, "R7 busy clear after eight edges", d[7], 0);
        bus_read(0, d);
        check(d == 8'h80, "R7 data after counted transfer", d, 8'h80);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        logic s;
        bus_write(1, 8'h00);
        bus_write(0, 8'h5A);
        bus_write(1, 8'h80);
        bus_read(1, d);
        check(d == 8'h00, "R8 busy ignored when off", d, 0);
        check(!sdo_oe && !sclk_oe, "R10 enables off", {sclk_oe, sdo_oe}, 0);
        s_pulse(1'b1, s);
        s_pulse(1'b1, s);
        bus_read(0, d);
        check(d == 8'h5A, "R8 pin edges ignored when off", d, 8'h5A);
        bus_write(1, 8'h8F);
        wait_cyc(5);
        bus_write(1, 8'h00);
        bus_read(1, d);
        check(d[7] == 1'b0 && !sclk_out, "R8 disable ends transfer", {d[7], sclk_out}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(2);
        t_reset();
        t_master(2'b00, 8'hA5, 8'hFF, 0);
        t_master(2'b01, 8'h3C, 8'h00, 0);
        t_master(2'b10, 8'h96, 8'hC5, 1);
        t_master(2'b11, 8'h0F, 8'h71, 1);
        t_abort_and_locked_data();
        t_slave();
        t_extra_bit();
        t_disabled();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule